// File: doc/BRIEF.md
# Keyed Register Commit Controller

This block is the bus-side front end of a battery-backed timekeeper. Host writes land in a set of shadow registers in the fast bus clock domain. Nothing reaches the slow timekeeping domain until the host writes a 1 to a trigger register. That write hands a snapshot of every shadow word to the slow domain, where it is copied into the live registers after a fixed number of slow-clock cycles. A busy flag covers the whole transfer.

Three access rules protect the live state:
- **Keyed control writes.** A write to the control register acts only when it carries a tag byte.
- **Protection unlock.** Time and alarm words stay read-only until a two-word unlock sequence has been written and committed.
- **Power-key gating.** The two power-key words can be written only after the two configuration words have been committed with their required values.

After every commit the block checks the committed power keys. A power-lost flag stays high until both keys hold their expected values.

The write port is a valid/ready stream of address and data words. A write is taken on a rising clock edge when both wr_valid and wr_ready are high. While a commit is in flight, wr_ready is low for every address except the control and trigger addresses. This holds the shadow contents still while the slow domain copies them. The host must keep wr_valid, wr_addr and wr_data stable until the write is taken. Reads are combinational from rd_addr.

Top module: `keyed_commit_ctrl`

## Requirements
- R1: After reset the outputs are as follows:
  - busy, unlocked and every live word are 0.
  - pwr_lost is 1.
  - Every shadow word reads 0.
  - The protection state reads 0.
- R2: A taken write of data bit 0 = 1 to the trigger address 0x78 while idle starts a commit.
  - busy is 1 from the next cycle, and control register 0x00 reads bit 6 = 1 during that time.
  - When busy falls, live_data equals the shadow snapshot taken at the trigger. Word k sits at bits [16k+15:16k].
  - The shadow words are, in order: NUM_DATA data words, then config word 0, config word 1, key word 1 and key word 2.
- R3: A trigger write taken while busy is ignored: no second commit follows.
- R4: A control write acts only when data[15:8] = 0x43, and only while idle.
  - Bit 4 clears both key shadow words.
  - Bit 5 reloads the data shadow words from the live words.
  - Any other tag byte leaves every shadow word unchanged.
- R5: While busy, wr_ready is 0 for every address other than 0x00 and 0x78, and the shadow words do not change.
- R6: The protection state at 0x70 reads 0 when locked, 1 after 0x9136 has been written there and committed, and 2 (unlocked = 1) after 0x586A has then been written and committed. Once reached, state 2 remains until reset.
- R7: In state 1, any taken write other than 0x586A to 0x70, or a trigger without that word pending, returns the state to 0.
- R8: While unlocked is 0, writes to the data words at 0x14 + 4k are ignored.
- R9: Writes to the key words at 0x4C and 0x50 are ignored until 0x4848 at 0x5C and 0x0048 at 0x60 have been committed. Configuration writes are always accepted when the port is ready.
- R10: pwr_lost changes only in the cycle busy falls. It then becomes 0 exactly when the committed keys are 0xA357 at 0x4C and 0x67D2 at 0x50, and 1 otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| slow_clk | input | 1 | Timekeeping domain clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| wr_valid | input | 1 | Write request valid |
| wr_ready | output | 1 | Write can be taken this cycle |
| wr_addr | input | 8 | Write byte address |
| wr_data | input | 16 | Write data |
| rd_addr | input | 8 | Read byte address |
| rd_data | output | 16 | Combinational read data |
| busy | output | 1 | Commit in flight |
| pwr_lost | output | 1 | Committed power keys invalid |
| unlocked | output | 1 | Protection sequence completed |
| live_data | output | 16*(NUM_DATA+4) | Committed words, slow-domain registers |

## Verification
The commit path is exercised with the following patterns:
- **Bit patterns.** Several data patterns (alternating bits, all ones, a single low bit, a single high bit) are committed. A scoreboard compares every live word against the snapshot the bench expected, which would expose swapped or dropped words.
- **Ordering and tags.** The unlock words are tried both as a correct pair and with a foreign write between them, which separates a sequence detector from a plain value match. The control write is tried with a wrong tag and with the right one.
- **Power keys.** Keys are written before and after the configuration commit, and both correct and partly wrong key pairs are committed. This distinguishes write gating from the power-lost evaluation.
- **Commit timing.** A trigger is issued during a commit to show that it does not start a second transfer.

// File: rtl/kc_pkg.sv
package kc_pkg;
  localparam int DW = 16;

  localparam logic [7:0] A_CTRL  = 8'h00;
  localparam logic [7:0] A_DATA0 = 8'h14;
  localparam logic [7:0] A_KEY1  = 8'h4C;
  localparam logic [7:0] A_KEY2  = 8'h50;
  localparam logic [7:0] A_CFG0  = 8'h5C;
  localparam logic [7:0] A_CFG1  = 8'h60;
  localparam logic [7:0] A_PROT  = 8'h70;
  localparam logic [7:0] A_TRIG  = 8'h78;

  localparam logic [DW-1:0] KEY1_GOOD = 16'hA357;
  localparam logic [DW-1:0] KEY2_GOOD = 16'h67D2;
  localparam logic [DW-1:0] CFG0_GOOD = 16'h4848;
  localparam logic [DW-1:0] CFG1_GOOD = 16'h0048;
  localparam logic [DW-1:0] UNLK_FIRST  = 16'h9136;
  localparam logic [DW-1:0] UNLK_SECOND = 16'h586A;

  localparam logic [7:0] CTRL_TAG = 8'h43;
  localparam int BIT_BUSY   = 6;
  localparam int BIT_RELOAD = 5;
  localparam int BIT_CLRKEY = 4;

  typedef enum logic [1:0] {
    PS_LOCKED = 2'd0,
    PS_HALF   = 2'd1,
    PS_OPEN   = 2'd2
  } prot_st_t;
endpackage

// File: rtl/kc_commit_xfer.sv
module kc_commit_xfer #(
  parameter int WORDS      = 8,
  parameter int COMMIT_CYC = 4,
  localparam int VW = WORDS * kc_pkg::DW,
  localparam int CW = $clog2(COMMIT_CYC + 1)
) (
  input  logic          clk,
  input  logic          slow_clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [VW-1:0] shadow,
  output logic [VW-1:0] live,
  output logic          busy,
  output logic          done
);
  // bus domain: request toggle and returning acknowledge synchronizer
  logic req_tgl, ack_s1, ack_s2;
  // slow domain
  logic rq_s1, rq_s2, rq_s3, running, ack_tgl;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_tgl <= 1'b0;
      ack_s1  <= 1'b0;
      ack_s2  <= 1'b0;
    end else begin
      if (go) req_tgl <= ~req_tgl;
      ack_s1 <= ack_tgl;
      ack_s2 <= ack_s1;
    end
  end

  assign busy = req_tgl ^ ack_s2;
  assign done = ack_s1 ^ ack_s2;

  always_ff @(posedge slow_clk or negedge rst_n) begin
    if (!rst_n) begin
      rq_s1   <= 1'b0;
      rq_s2   <= 1'b0;
      rq_s3   <= 1'b0;
      running <= 1'b0;
      cnt     <= '0;
      ack_tgl <= 1'b0;
      live    <= '0;
    end else begin
      rq_s1 <= req_tgl;
      rq_s2 <= rq_s1;
      rq_s3 <= rq_s2;
      if (running) begin
        if (cnt == CW'(COMMIT_CYC - 1)) begin
          live    <= shadow;
          ack_tgl <= ~ack_tgl;
          running <= 1'b0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end else if (rq_s2 ^ rq_s3) begin
        running <= 1'b1;
        cnt     <= '0;
      end
    end
  end

  AST_GO_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> !busy); // R3
  AST_DONE_INSIDE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy); // R2
  AST_BUSY_AFTER_GO: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> busy); // R2
endmodule

// File: rtl/kc_prot_fsm.sv
module kc_prot_fsm (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_acc,
  input  logic [7:0]           wr_addr,
  input  logic [kc_pkg::DW-1:0] wr_data,
  input  logic                 go,
  output kc_pkg::prot_st_t     state
);
  import kc_pkg::*;

  logic [DW-1:0] pval;
  logic          pfresh;
  logic          second_word;

  assign second_word = wr_acc && (wr_addr == A_PROT) && (wr_data == UNLK_SECOND);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pval   <= '0;
      pfresh <= 1'b0;
      state  <= PS_LOCKED;
    end else begin
      if (wr_acc && wr_addr == A_PROT) begin
        pval   <= wr_data;
        pfresh <= 1'b1;
      end else if (go) begin
        pfresh <= 1'b0;
      end
      case (state)
        PS_LOCKED:
          if (go && pfresh && pval == UNLK_FIRST) state <= PS_HALF;
        PS_HALF:
          if (go) state <= (pfresh && pval == UNLK_SECOND) ? PS_OPEN : PS_LOCKED;
          else if (wr_acc && !second_word) state <= PS_LOCKED;
        PS_OPEN:
          state <= PS_OPEN;
        default:
          state <= PS_LOCKED;
      endcase
    end
  end

  AST_OPEN_NEEDS_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PS_OPEN && $past(state) != PS_OPEN) |-> $past(go)); // R6
  AST_HALF_NEEDS_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PS_HALF && $past(state) == PS_LOCKED) |-> $past(go)); // R6
  AST_FOREIGN_RELOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PS_HALF && wr_acc && wr_addr != A_PROT && !go) |=> state == PS_LOCKED); // R7
endmodule

// File: rtl/kc_shadow_regs.sv
module kc_shadow_regs #(
  parameter int NUM_DATA = 4,
  localparam int WORDS = NUM_DATA + 4,
  localparam int VW    = WORDS * kc_pkg::DW,
  localparam int DVW   = NUM_DATA * kc_pkg::DW
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_acc,
  input  logic [7:0]            wr_addr,
  input  logic [kc_pkg::DW-1:0] wr_data,
  input  logic                  busy,
  input  logic                  unlocked,
  input  logic                  cfg_ok,
  input  logic [DVW-1:0]        live_words,
  output logic [VW-1:0]         shadow
);
  import kc_pkg::*;

  logic          wacc_ok, ctrl_ok, do_reload, do_clr;
  logic [DW-1:0] sh [WORDS];
  logic          we [WORDS];
  logic [DW-1:0] wv [WORDS];

  assign wacc_ok   = wr_acc && !busy;
  assign ctrl_ok   = wacc_ok && (wr_addr == A_CTRL) && (wr_data[15:8] == CTRL_TAG);
  assign do_reload = ctrl_ok && wr_data[BIT_RELOAD];
  assign do_clr    = ctrl_ok && wr_data[BIT_CLRKEY];

  for (genvar k = 0; k < WORDS; k++) begin : g_word
    if (k < NUM_DATA) begin : g_data
      localparam logic [7:0] ADR = 8'(A_DATA0 + 4 * k);
      always_comb begin
        we[k] = do_reload || (wacc_ok && unlocked && wr_addr == ADR);
        wv[k] = do_reload ? live_words[k*DW +: DW] : wr_data;
      end
    end else if (k < NUM_DATA + 2) begin : g_cfg
      localparam logic [7:0] ADR = (k == NUM_DATA) ? A_CFG0 : A_CFG1;
      always_comb begin
        we[k] = wacc_ok && wr_addr == ADR;
        wv[k] = wr_data;
      end
    end else begin : g_key
      localparam logic [7:0] ADR = (k == NUM_DATA + 2) ? A_KEY1 : A_KEY2;
      always_comb begin
        we[k] = do_clr || (wacc_ok && cfg_ok && wr_addr == ADR);
        wv[k] = do_clr ? '0 : wr_data;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     sh[k] <= '0;
      else if (we[k]) sh[k] <= wv[k];
    end

    assign shadow[k*DW +: DW] = sh[k];
  end

  AST_SHADOW_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    $past(busy) |-> $stable(shadow)); // R5
  AST_DATA_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!unlocked && !do_reload) |-> $stable(shadow[DVW-1:0])); // R8
  AST_KEYS_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!cfg_ok && !do_clr) |-> $stable(shadow[VW-1 -: 2*DW])); // R9
endmodule

// File: rtl/keyed_commit_ctrl.sv
module keyed_commit_ctrl #(
  parameter int NUM_DATA   = 4,
  parameter int COMMIT_CYC = 4,
  parameter int BUSY_LIMIT = 4096,
  localparam int WORDS = NUM_DATA + 4,
  localparam int VW    = WORDS * kc_pkg::DW,
  localparam int DVW   = NUM_DATA * kc_pkg::DW,
  localparam int BCW   = $clog2(BUSY_LIMIT + 1)
) (
  input  logic          clk,
  input  logic          slow_clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  output logic          wr_ready,
  input  logic [7:0]    wr_addr,
  input  logic [15:0]   wr_data,
  input  logic [7:0]    rd_addr,
  output logic [15:0]   rd_data,
  output logic          busy,
  output logic          pwr_lost,
  output logic          unlocked,
  output logic [VW-1:0] live_data
);
  import kc_pkg::*;

  logic          wr_acc, go, done, cfg_ok;
  logic [VW-1:0] shadow;
  prot_st_t      pstate;

  assign wr_ready = !busy || wr_addr == A_CTRL || wr_addr == A_TRIG;
  assign wr_acc   = wr_valid && wr_ready;
  assign go       = wr_acc && wr_addr == A_TRIG && wr_data[0] && !busy;
  assign unlocked = (pstate == PS_OPEN);

  kc_prot_fsm u_prot (
    .clk(clk), .rst_n(rst_n), .wr_acc(wr_acc), .wr_addr(wr_addr),
    .wr_data(wr_data), .go(go), .state(pstate)
  );

  kc_shadow_regs #(.NUM_DATA(NUM_DATA)) u_shadow (
    .clk(clk), .rst_n(rst_n), .wr_acc(wr_acc), .wr_addr(wr_addr),
    .wr_data(wr_data), .busy(busy), .unlocked(unlocked), .cfg_ok(cfg_ok),
    .live_words(live_data[DVW-1:0]), .shadow(shadow)
  );

  kc_commit_xfer #(.WORDS(WORDS), .COMMIT_CYC(COMMIT_CYC)) u_xfer (
    .clk(clk), .slow_clk(slow_clk), .rst_n(rst_n), .go(go),
    .shadow(shadow), .live(live_data), .busy(busy), .done(done)
  );

  // live words are quiet once the acknowledge is on its way back
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwr_lost <= 1'b1;
      cfg_ok   <= 1'b0;
    end else if (done) begin
      pwr_lost <= !(live_data[(NUM_DATA+2)*DW +: DW] == KEY1_GOOD &&
                    live_data[(NUM_DATA+3)*DW +: DW] == KEY2_GOOD);
      cfg_ok   <= (live_data[NUM_DATA*DW +: DW] == CFG0_GOOD &&
                   live_data[(NUM_DATA+1)*DW +: DW] == CFG1_GOOD);
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_CTRL: rd_data[BIT_BUSY] = busy;
      A_PROT: rd_data = {14'b0, pstate};
      A_CFG0: rd_data = shadow[NUM_DATA*DW +: DW];
      A_CFG1: rd_data = shadow[(NUM_DATA+1)*DW +: DW];
      A_KEY1: rd_data = shadow[(NUM_DATA+2)*DW +: DW];
      A_KEY2: rd_data = shadow[(NUM_DATA+3)*DW +: DW];
      default: begin
        for (int k = 0; k < NUM_DATA; k++)
          if (rd_addr == 8'(A_DATA0 + 4 * k)) rd_data = shadow[k*DW +: DW];
      end
    endcase
  end

  logic [BCW-1:0] busy_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    busy_cnt <= '0;
    else if (busy) busy_cnt <= (busy_cnt == BCW'(BUSY_LIMIT)) ? busy_cnt : busy_cnt + 1'b1;
    else           busy_cnt <= '0;
  end

  AST_BUSY_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    busy_cnt < BCW'(BUSY_LIMIT)); // R2
  AST_PWR_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_lost != $past(pwr_lost)) |-> ($past(busy) && !busy)); // R10
endmodule

// File: tb/sim_keyed_commit_ctrl.sv
module sim_keyed_commit_ctrl;
  localparam int ND = 4;
  localparam int NW = ND + 4;
  localparam int VW = NW * 16;

  logic clk = 1'b0, slow_clk = 1'b0, rst_n = 1'b0;
  logic wr_valid = 1'b0, wr_ready;
  logic [7:0] wr_addr = '0, rd_addr = '0;
  logic [15:0] wr_data = '0, rd_data;
  logic busy, pwr_lost, unlocked;
  logic [VW-1:0] live_data;

  always #4 clk = ~clk;
  always #20 slow_clk = ~slow_clk;

  keyed_commit_ctrl #(.NUM_DATA(ND)) u0 (
    .clk(clk), .slow_clk(slow_clk), .rst_n(rst_n), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy),
    .pwr_lost(pwr_lost), .unlocked(unlocked), .live_data(live_data)
  );

  int n_chk = 0, n_fail = 0;
  logic [15:0] m [NW];
  logic [VW:0] sb_q [$];

  task automatic chk(input string req, input logic [VW-1:0] act, input logic [VW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [VW-1:0] flat();
    logic [VW-1:0] f;
    for (int k = 0; k < NW; k++) f[k*16 +: 16] = m[k];
    return f;
  endfunction

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [15:0] d);
    @(negedge clk);
    rd_addr = a;
    #1 d = rd_data;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic commit(input logic exp_pwr);
    sb_q.push_back({exp_pwr, flat()});
    wr(8'h78, 16'h0001);
    chk("R2 busy after trigger", VW'(busy), VW'(1));
  endtask

  // monitor: compare live words and power flag when a commit completes
  logic busy_d = 1'b0;
  always @(negedge clk) begin
    if (busy_d && !busy) begin
      if (sb_q.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL R3: commit finished with nothing expected, actual 1 expected 0");
      end else begin
        logic [VW:0] e;
        e = sb_q.pop_front();
        chk("R2 live words", live_data, e[VW-1:0]);
        chk("R10 pwr_lost after commit", VW'(pwr_lost), VW'(e[VW]));
      end
    end
    busy_d <= busy;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] d;
    for (int k = 0; k < NW; k++) m[k] = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 busy", VW'(busy), VW'(0));
    chk("R1 pwr_lost", VW'(pwr_lost), VW'(1));
    chk("R1 unlocked", VW'(unlocked), VW'(0));
    chk("R1 live", live_data, '0);
    rd(8'h00, d); chk("R1 ctrl", VW'(d), VW'(0));
    rd(8'h70, d); chk("R1 prot", VW'(d), VW'(0));

    // R8 data write while locked
    wr(8'h14, 16'h1111);
    rd(8'h14, d); chk("R8 locked data write", VW'(d), VW'(0));

    // R9 key write before config committed
    wr(8'h5C, 16'h4848); m[ND] = 16'h4848;
    wr(8'h60, 16'h0048); m[ND+1] = 16'h0048;
    wr(8'h4C, 16'hA357);
    rd(8'h4C, d); chk("R9 key gated", VW'(d), VW'(0));

    // commit with R2 / R3 / R5 probing during busy
    commit(1'b1);
    rd(8'h00, d); chk("R2 ctrl busy bit", VW'(d), VW'(16'h0040));
    @(negedge clk); wr_addr = 8'h14; #1 chk("R5 ready low on data", VW'(wr_ready), VW'(0));
    wr_addr = 8'h78; #1 chk("R5 ready on trigger", VW'(wr_ready), VW'(1));
    wr(8'h78, 16'h0001);
    wait_idle();
    repeat (60) @(negedge clk);
    chk("R3 no second commit", VW'(busy), VW'(0));

    // R9 keys now writable, R10 clears
    wr(8'h4C, 16'hA357); m[ND+2] = 16'hA357;
    wr(8'h50, 16'h67D2); m[ND+3] = 16'h67D2;
    rd(8'h4C, d); chk("R9 key accepted", VW'(d), VW'(16'hA357));
    commit(1'b0); wait_idle();

    // R7 broken unlock
    wr(8'h70, 16'h9136); commit(1'b0); wait_idle();
    rd(8'h70, d); chk("R6 half state", VW'(d), VW'(1));
    wr(8'h5C, 16'h4848);
    rd(8'h70, d); chk("R7 relocked", VW'(d), VW'(0));

    // R6 full unlock
    wr(8'h70, 16'h9136); commit(1'b0); wait_idle();
    wr(8'h70, 16'h586A); commit(1'b0); wait_idle();
    chk("R6 unlocked", VW'(unlocked), VW'(1));
    rd(8'h70, d); chk("R6 open state", VW'(d), VW'(2));

    // R2 data patterns
    wr(8'h14, 16'hA5A5); m[0] = 16'hA5A5;
    wr(8'h18, 16'h5A5A); m[1] = 16'h5A5A;
    wr(8'h1C, 16'hFFFF); m[2] = 16'hFFFF;
    wr(8'h20, 16'h0001); m[3] = 16'h0001;
    commit(1'b0); wait_idle();
    wr(8'h14, 16'h0000); m[0] = 16'h0000;
    wr(8'h18, 16'h8000); m[1] = 16'h8000;
    commit(1'b0); wait_idle();

    // R4 keyed control
    wr(8'h00, 16'h0010);
    rd(8'h4C, d); chk("R4 wrong tag ignored", VW'(d), VW'(16'hA357));
    wr(8'h00, 16'h4310); m[ND+2] = '0; m[ND+3] = '0;
    rd(8'h4C, d); chk("R4 clear key1", VW'(d), VW'(0));
    rd(8'h50, d); chk("R4 clear key2", VW'(d), VW'(0));
    wr(8'h14, 16'h1234);
    wr(8'h00, 16'h4320);
    rd(8'h14, d); chk("R4 reload word0", VW'(d), VW'(16'h0000));
    rd(8'h18, d); chk("R4 reload word1", VW'(d), VW'(16'h8000));
    commit(1'b1); wait_idle();

    // R10 partly wrong then correct keys
    wr(8'h4C, 16'hA357); m[ND+2] = 16'hA357;
    wr(8'h50, 16'h1234); m[ND+3] = 16'h1234;
    commit(1'b1); wait_idle();
    wr(8'h50, 16'h67D2); m[ND+3] = 16'h67D2;
    commit(1'b0); wait_idle();

    repeat (4) @(negedge clk);
    chk("R2 scoreboard drained", VW'(sb_q.size()), VW'(0));
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule